// File: doc/BRIEF.md
# Serial Configuration Register Bank for Multi-Channel Motor Control

This block receives 8-bit configuration frames over a three-wire write-only serial link (shift clock, data, strobe) and turns them into the control fields that drive three stepping-motor sequencers and a pair of H-bridge channels. The two lowest bits of each frame pick one of four registers: a monitor/mode register, a register for each of two stepper channels, and a register for the shared channel-5/6 pair. The channel-5/6 pair works either as two direct PWM bridges or as a third stepper.

The fields take effect at different times. Hold, monitor, reference and PWM fields apply as soon as the strobe latches the frame. Reset and output-enable fields wait for the next rising edge of that channel's step clock. Direction and step mode wait for a falling edge and then a rising edge of the step clock. All serial and step-clock inputs are sampled by the system clock through synchronizers, so the block has one clock domain.

Top module: `scfg_bank`

## Requirements
- R1: After reset every output is 0, except the third stepper's step mode `st_mode[5:4]`, which reads 2'b10.
- R2: Bits shift in least significant first on each rising edge of `ser_clk`. A rising edge of `ser_stb` writes the frame to the register that bits 1:0 select: 00 monitor/mode, 01 stepper A, 10 stepper B, 11 channel 5/6. The other registers keep their values.
- R3: These fields apply at the strobe, before any step-clock edge. Monitor register: bits 3:2 give `mon_src`, bits 4/5/6 give `mon_qtr[0]/[1]/[2]`, bit 7 gives `ch56_step_mode`. Stepper bit 5 gives `st_hold`. Channel-5/6 register: bit 3 gives `st_hold[2]` and bits 7:6 give `vref_sel`. In the same register, bit 2 gives `pwm_dir[0]`, bit 3 `pwm_decay[0]`, bit 4 `pwm_dir[1]` and bit 5 `pwm_decay[1]`.
- R4: The reset and enable fields reach `st_nrst`/`st_oen` on the first rising edge of that channel's step clock after the strobe, and not before. In a stepper register they are bit 6 and bit 7; in the channel-5/6 register they are bit 4 and bit 5.
- R5: Direction (stepper bit 2, channel-5/6 bit 2) and step mode (stepper bits 4:3) reach `st_dir`/`st_mode` only on a rising step-clock edge that follows a falling edge seen after the strobe. A rising edge with no such falling edge leaves them unchanged.
- R6: Each channel's pending fields react only to that channel's own step clock (`step_clk[0]` stepper A, `[1]` stepper B, `[2]` channel 5/6).
- R7: A new frame to the same register before its fields apply replaces the pending values and restarts the wait for the step-clock edges.
- R8: The third stepper's step mode stays 2'b10 whatever the channel-5/6 register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data, least significant bit first |
| ser_stb | input | 1 | Strobe; its rising edge latches the frame |
| step_clk | input | 3 | Step clocks of stepper A, stepper B and channel 5/6 |
| st_dir | output | 3 | Active direction per stepper |
| st_mode | output | 6 | Active step mode, 2 bits per stepper |
| st_hold | output | 3 | Active step hold per stepper |
| st_nrst | output | 3 | Active position reset per stepper, low = reset |
| st_oen | output | 3 | Active output enable per stepper |
| mon_src | output | 2 | Monitor pin source select |
| mon_qtr | output | 3 | Monitor quarter-period mode per stepper |
| ch56_step_mode | output | 1 | Channel 5/6 works as a stepper when 1 |
| vref_sel | output | 2 | Channel 5/6 current reference select |
| pwm_dir | output | 2 | PWM direction of channels 5 and 6 |
| pwm_decay | output | 2 | PWM decay mode of channels 5 and 6 |

## Verification
Frames go to all four registers, with the target step clock low at the strobe and also high at the strobe. The low case shows the split between reset/enable (first rise) and direction/mode (fall then rise). The high case shows that one fall and one rise apply both groups together. Pulses on a foreign step clock while fields are pending show whether channels are kept apart. Two back-to-back frames before any edge show whether the later frame replaces the pending values. Frames with different bit patterns in the channel-5/6 register show the PWM field positions and the fixed third-stepper mode.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int FRAME_W = 8;
  localparam int NSTP    = 3;

  // register select codes carried in frame bits 1:0
  localparam logic [1:0] SEL_MON = 2'b00;
  localparam logic [1:0] SEL_STA = 2'b01;
  localparam logic [1:0] SEL_STB = 2'b10;
  localparam logic [1:0] SEL_C56 = 2'b11;

  // the third stepper only runs one step mode
  localparam logic [1:0] C56_FIXED_MODE = 2'b10;

  typedef enum logic [1:0] {
    PA_IDLE      = 2'd0,
    PA_WAIT_FALL = 2'd1,
    PA_WAIT_RISE = 2'd2
  } pend_a_t;

  typedef struct packed {
    logic       dir;
    logic [1:0] mode;
    logic       nrst;
    logic       oen;
  } stage_fields_t;
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
      prev <= '0;
    end else begin
      pipe[0] <= din;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/scfg_shift.sv
module scfg_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sck_rise,
  input  logic         sdat,
  input  logic         stb_rise,
  output logic         frame_vld,
  output logic [W-1:0] frame
);
  logic [W-1:0] shreg;

  // first bit in ends at bit 0 after W shifts
  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else if (sck_rise) shreg <= {sdat, shreg[W-1:1]};
  end

  assign frame_vld = stb_rise;
  assign frame     = shreg;
endmodule

// File: rtl/scfg_stage.sv
module scfg_stage
  import scfg_pkg::*;
#(
  parameter logic [1:0] RST_MODE = 2'b00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  stage_fields_t wr_fields,
  input  logic          stp_rise,
  input  logic          stp_fall,
  output stage_fields_t act
);
  stage_fields_t shadow;
  pend_a_t       pa;
  logic          pb;

  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= '{dir: 1'b0, mode: RST_MODE, nrst: 1'b0, oen: 1'b0};
      shadow <= '{dir: 1'b0, mode: RST_MODE, nrst: 1'b0, oen: 1'b0};
      pa     <= PA_IDLE;
      pb     <= 1'b0;
    end else if (wr) begin
      // a new frame restarts both waits
      shadow <= wr_fields;
      pa     <= PA_WAIT_FALL;
      pb     <= 1'b1;
    end else begin
      if (stp_rise && pb) begin
        act.nrst <= shadow.nrst;
        act.oen  <= shadow.oen;
        pb       <= 1'b0;
      end
      if (stp_rise && pa == PA_WAIT_RISE) begin
        act.dir  <= shadow.dir;
        act.mode <= shadow.mode;
        pa       <= PA_IDLE;
      end
      if (stp_fall && pa == PA_WAIT_FALL) pa <= PA_WAIT_RISE;
    end
  end
endmodule

// File: rtl/scfg_bank.sv
module scfg_bank
  import scfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ser_clk,
  input  logic            ser_dat,
  input  logic            ser_stb,
  input  logic [NSTP-1:0] step_clk,
  output logic [NSTP-1:0] st_dir,
  output logic [2*NSTP-1:0] st_mode,
  output logic [NSTP-1:0] st_hold,
  output logic [NSTP-1:0] st_nrst,
  output logic [NSTP-1:0] st_oen,
  output logic [1:0]      mon_src,
  output logic [NSTP-1:0] mon_qtr,
  output logic            ch56_step_mode,
  output logic [1:0]      vref_sel,
  output logic [1:0]      pwm_dir,
  output logic [1:0]      pwm_decay
);
  localparam int SW = 3 + NSTP;

  logic [SW-1:0] s_lvl, s_rise, s_fall;
  logic          frame_vld;
  logic [FRAME_W-1:0] frame;
  logic          sig_unused;

  scfg_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({step_clk, ser_stb, ser_dat, ser_clk}),
    .lvl  (s_lvl),
    .rise (s_rise),
    .fall (s_fall)
  );

  assign sig_unused = ^{s_lvl[SW-1:2], s_lvl[0], s_rise[1], s_fall[2:0]};

  scfg_shift #(.W(FRAME_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .sck_rise  (s_rise[0]),
    .sdat      (s_lvl[1]),
    .stb_rise  (s_rise[2]),
    .frame_vld (frame_vld),
    .frame     (frame)
  );

  logic wr_mon, wr_sa, wr_sb, wr_c56;
  assign wr_mon = frame_vld && frame[1:0] == SEL_MON;
  assign wr_sa  = frame_vld && frame[1:0] == SEL_STA;
  assign wr_sb  = frame_vld && frame[1:0] == SEL_STB;
  assign wr_c56 = frame_vld && frame[1:0] == SEL_C56;

  // fields that apply at the strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      mon_src        <= '0;
      mon_qtr        <= '0;
      ch56_step_mode <= 1'b0;
      st_hold        <= '0;
      vref_sel       <= '0;
      pwm_dir        <= '0;
      pwm_decay      <= '0;
    end else begin
      if (wr_mon) begin
        mon_src        <= frame[3:2];
        mon_qtr        <= frame[6:4];
        ch56_step_mode <= frame[7];
      end
      if (wr_sa) st_hold[0] <= frame[5];
      if (wr_sb) st_hold[1] <= frame[5];
      if (wr_c56) begin
        st_hold[2]   <= frame[3];
        vref_sel     <= frame[7:6];
        pwm_dir[0]   <= frame[2];
        pwm_decay[0] <= frame[3];
        pwm_dir[1]   <= frame[4];
        pwm_decay[1] <= frame[5];
      end
    end
  end

  // fields that wait for step-clock edges
  logic          stg_wr [NSTP];
  stage_fields_t stg_in [NSTP];
  stage_fields_t stg_act[NSTP];

  generate
    for (genvar i = 0; i < NSTP; i++) begin : g_stp
      if (i == NSTP - 1) begin : g_c56
        assign stg_wr[i] = wr_c56;
        assign stg_in[i] = '{dir: frame[2], mode: C56_FIXED_MODE,
                             nrst: frame[4], oen: frame[5]};
        scfg_stage #(.RST_MODE(C56_FIXED_MODE)) u_stage (
          .clk       (clk),
          .rst       (rst),
          .wr        (stg_wr[i]),
          .wr_fields (stg_in[i]),
          .stp_rise  (s_rise[3+i]),
          .stp_fall  (s_fall[3+i]),
          .act       (stg_act[i])
        );
      end else begin : g_full
        assign stg_wr[i] = (i == 0) ? wr_sa : wr_sb;
        assign stg_in[i] = '{dir: frame[2], mode: frame[4:3],
                             nrst: frame[6], oen: frame[7]};
        scfg_stage #(.RST_MODE(2'b00)) u_stage (
          .clk       (clk),
          .rst       (rst),
          .wr        (stg_wr[i]),
          .wr_fields (stg_in[i]),
          .stp_rise  (s_rise[3+i]),
          .stp_fall  (s_fall[3+i]),
          .act       (stg_act[i])
        );
      end
      assign st_dir[i]       = stg_act[i].dir;
      assign st_mode[2*i+:2] = stg_act[i].mode;
      assign st_nrst[i]      = stg_act[i].nrst;
      assign st_oen[i]       = stg_act[i].oen;
    end
  endgenerate
endmodule

// File: rtl/scfg_bank_chk.sv
module scfg_bank_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         ser_stb,
  input logic [N-1:0] step_clk,
  input logic [N-1:0] st_dir,
  input logic [2*N-1:0] st_mode,
  input logic [N-1:0] st_hold,
  input logic [N-1:0] st_nrst,
  input logic [N-1:0] st_oen,
  input logic [1:0]   mon_src,
  input logic [N-1:0] mon_qtr,
  input logic         ch56_step_mode,
  input logic [1:0]   vref_sel,
  input logic [1:0]   pwm_dir,
  input logic [1:0]   pwm_decay
);
  // observer's own view of the strobe and step-clock edges
  logic [N:0] pipe [SYNC_STAGES];
  logic [N:0] prev;
  logic [N:0] seen_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) pipe[s] <= '0;
      prev <= '0;
    end else begin
      pipe[0] <= {step_clk, ser_stb};
      for (int s = 1; s < SYNC_STAGES; s++) pipe[s] <= pipe[s-1];
      prev <= pipe[SYNC_STAGES-1];
    end
  end
  assign seen_rise = pipe[SYNC_STAGES-1] & ~prev;

  AST_MON_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$stable({mon_src, mon_qtr, ch56_step_mode}) |-> $past(seen_rise[0])); // R2

  AST_HOLD_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$stable(st_hold) |-> $past(seen_rise[0])); // R3

  AST_PWM_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$stable({vref_sel, pwm_dir, pwm_decay}) |-> $past(seen_rise[0])); // R3

  generate
    for (genvar i = 0; i < N; i++) begin : g_ch
      AST_ENA_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable({st_nrst[i], st_oen[i]}) |-> $past(seen_rise[i+1])); // R4

      AST_DIR_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable({st_dir[i], st_mode[2*i+:2]}) |-> $past(seen_rise[i+1])); // R5
    end
  endgenerate
endmodule

bind scfg_bank scfg_bank_chk #(.SYNC_STAGES(SYNC_STAGES), .N(scfg_pkg::NSTP)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .ser_stb        (ser_stb),
  .step_clk       (step_clk),
  .st_dir         (st_dir),
  .st_mode        (st_mode),
  .st_hold        (st_hold),
  .st_nrst        (st_nrst),
  .st_oen         (st_oen),
  .mon_src        (mon_src),
  .mon_qtr        (mon_qtr),
  .ch56_step_mode (ch56_step_mode),
  .vref_sel       (vref_sel),
  .pwm_dir        (pwm_dir),
  .pwm_decay      (pwm_decay)
);

// File: tb/sim_scfg_bank.sv
`timescale 1ns/1ps
module sim_scfg_bank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_stb = 1'b0;
  logic [2:0] step_clk = 3'b000;
  logic [2:0] st_dir, st_hold, st_nrst, st_oen, mon_qtr;
  logic [5:0] st_mode;
  logic [1:0] mon_src, vref_sel, pwm_dir, pwm_decay;
  logic       ch56_step_mode;

  always #4 clk = ~clk; // 125 MHz

  scfg_bank u0 (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb),
    .step_clk(step_clk), .st_dir(st_dir), .st_mode(st_mode), .st_hold(st_hold),
    .st_nrst(st_nrst), .st_oen(st_oen), .mon_src(mon_src), .mon_qtr(mon_qtr),
    .ch56_step_mode(ch56_step_mode), .vref_sel(vref_sel), .pwm_dir(pwm_dir),
    .pwm_decay(pwm_decay)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // expected state, written by the test sequence from the requirements
  logic [2:0] e_dir = '0, e_hold = '0, e_nrst = '0, e_oen = '0, e_qtr = '0;
  logic [5:0] e_mode = 6'b10_00_00;
  logic [1:0] e_src = '0, e_vref = '0, e_pdir = '0, e_pdec = '0;
  logic       e_c56 = 1'b0;

  string      q_req[$];
  logic [29:0] q_exp[$];

  function automatic logic [29:0] pack_exp();
    return {e_dir, e_mode, e_hold, e_nrst, e_oen, e_src, e_qtr, e_c56, e_vref, e_pdir, e_pdec};
  endfunction

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q_exp.size() != 0) begin
        logic [29:0] act;
        logic [29:0] exp;
        string req;
        act = {st_dir, st_mode, st_hold, st_nrst, st_oen, mon_src, mon_qtr,
               ch56_step_mode, vref_sel, pwm_dir, pwm_decay};
        exp = q_exp.pop_front();
        req = q_req.pop_front();
        checks++;
        if (act !== exp) begin
          failures++;
          $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req);
    q_exp.push_back(pack_exp());
    q_req.push_back(req);
    wait (q_exp.size() == 0);
    wait_cyc(1);
  endtask

  task automatic send(input logic [7:0] b);
    for (int k = 0; k < 8; k++) begin
      ser_dat = b[k];
      wait_cyc(4);
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b0;
    end
    wait_cyc(4);
    ser_stb = 1'b1;
    wait_cyc(4);
    ser_stb = 1'b0;
    wait_cyc(4);
  endtask

  task automatic step(input int ch, input logic v);
    step_clk[ch] = v;
    wait_cyc(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);
    chk("R1 reset state");

    // monitor register
    send(8'hD4);
    e_src = 2'b01; e_qtr = 3'b101; e_c56 = 1'b1;
    chk("R2 R3 monitor fields at strobe");

    // stepper A, step clock low at strobe
    send(8'hFD);
    e_hold[0] = 1'b1;
    chk("R3 hold at strobe, R4 R5 nothing pending applied");
    step(0, 1'b1);
    e_nrst[0] = 1'b1; e_oen[0] = 1'b1;
    chk("R4 enable on first rise, R5 dir unchanged");
    step(0, 1'b0);
    chk("R5 no change on fall");
    step(0, 1'b1);
    e_dir[0] = 1'b1; e_mode[1:0] = 2'b11;
    chk("R5 dir and mode after fall then rise");

    // stepper B; foreign clock must not apply it
    send(8'hFE);
    e_hold[1] = 1'b1;
    chk("R2 R3 stepper B hold only");
    step(0, 1'b0); step(0, 1'b1); step(0, 1'b0); step(0, 1'b1);
    chk("R6 stepper A clock leaves B pending");
    step(1, 1'b1);
    e_nrst[1] = 1'b1; e_oen[1] = 1'b1;
    chk("R4 stepper B enable");
    step(1, 1'b0); step(1, 1'b1);
    e_dir[1] = 1'b1; e_mode[3:2] = 2'b11;
    chk("R5 stepper B dir and mode");

    // stepper A with step clock high at strobe
    send(8'h09);
    e_hold[0] = 1'b0;
    chk("R3 hold cleared at strobe");
    step(0, 1'b0);
    chk("R4 R5 fall alone applies nothing");
    step(0, 1'b1);
    e_nrst[0] = 1'b0; e_oen[0] = 1'b0; e_dir[0] = 1'b0; e_mode[1:0] = 2'b01;
    chk("R4 R5 both groups on the rise after fall");

    // replacement before application
    step(0, 1'b0);
    send(8'hFD);
    e_hold[0] = 1'b1;
    chk("R3 first frame hold");
    send(8'hD1);
    e_hold[0] = 1'b0;
    chk("R7 second frame hold replaces");
    step(0, 1'b1);
    e_nrst[0] = 1'b1; e_oen[0] = 1'b1;
    chk("R7 R5 enable from second frame, dir and mode waiting");
    step(0, 1'b0); step(0, 1'b1);
    e_mode[1:0] = 2'b10;
    chk("R7 mode from second frame");

    // channel 5/6 register
    send(8'hBF);
    e_vref = 2'b10; e_hold[2] = 1'b1; e_pdir = 2'b11; e_pdec = 2'b11;
    chk("R3 channel 5/6 immediate fields");
    step(2, 1'b1);
    e_nrst[2] = 1'b1; e_oen[2] = 1'b1;
    chk("R4 third stepper enable");
    step(2, 1'b0); step(2, 1'b1);
    e_dir[2] = 1'b1;
    chk("R5 R8 third stepper dir, mode fixed");

    send(8'h5B);
    e_vref = 2'b01; e_pdir = 2'b10; e_pdec = 2'b01;
    chk("R3 PWM field positions");
    step(2, 1'b0); step(2, 1'b1);
    e_oen[2] = 1'b0; e_dir[2] = 1'b0;
    chk("R4 R5 R8 third stepper second frame");

    send(8'h2C);
    e_src = 2'b11; e_qtr = 3'b010; e_c56 = 1'b0;
    chk("R2 monitor rewrite leaves others");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule